// File: doc/BRIEF.md
# Display Raster Timing Generator

This block produces the scan timing for a parallel RGB panel. It runs on the pixel clock and emits horizontal sync, vertical sync and a data-enable strobe. It also reports the position of the current pixel inside the visible area. Each line is divided into four phases in a fixed order: sync, back porch, active and front porch. Each frame is divided into the same four phases, counted in lines. The length of every phase, and the visible width and height, come from configuration inputs. Each of these inputs holds the real count minus one.

The configuration is copied into an internal working set only at a frame boundary, or at any time while the block is disabled. Software can therefore rewrite the timing at any moment without distorting the frame that is being scanned. The block has two notification outputs:

- A sticky frame interrupt. Its trigger point within the frame is selectable, and it is cleared by an acknowledge pulse.
- A single-cycle line-threshold pulse, which fires when the scan reaches a programmed visible line.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset, and in any cycle following a clock edge that saw `enable` low, hsync, vsync, de, line_hit, pos_x and pos_y are all 0. Reset also clears frame_irq.
- R2: A line lasts (h_sync_len+1)+(h_back_len+1)+(h_act_len+1)+(h_front_len+1) pixel clocks, in the order sync, back porch, active, front porch. hsync is 1 exactly during the first h_sync_len+1 clocks of each line.
- R3: A frame lasts (v_sync_len+1)+(v_back_len+1)+(v_act_len+1)+(v_front_len+1) lines, in the same phase order. vsync is 1 for every clock of the first v_sync_len+1 lines.
- R4: de is 1 only when both the line phase and the frame phase are active. pos_x is the 0-based pixel index while the line is in its active phase, and 0 otherwise. pos_y is the 0-based line index while the frame is in its active phase, and 0 otherwise.
- R5: The first cycle after the edge that samples `enable` high is the first clock of line 0 of a new frame, so hsync=1 and vsync=1 in that cycle.
- R6: Configuration inputs, including line_thr, take effect only at the start of a frame, or while disabled. A change made in the middle of a frame leaves the rest of that frame unchanged.
- R7: frame_irq is set when both irq_master_en and irq_frame_en are 1 and the event chosen by irq_frame_sel occurs. The selections are:
  - 0: the first clock of vsync of each frame that follows a completed frame.
  - 1: the first clock of the first visible line.
  - 2: the first clock of the first front-porch line.
  - 3: never.

  frame_irq becomes visible in the cycle in which the event clock is shown on the outputs.
- R8: line_hit is a one-cycle pulse on the first clock (the hsync start) of visible line number line_thr. It never fires when line_thr is greater than v_act_len.
- R9: frame_irq stays set until a clock edge that samples irq_ack high. If a new event and the acknowledge reach the same edge, the event wins.
- R10: When either irq_master_en or irq_frame_en is 0, frame_irq is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the scan; low holds the block idle at the frame start |
| h_sync_len | input | CW | hsync width in pixels, minus one |
| h_back_len | input | CW | Horizontal back porch in pixels, minus one |
| h_act_len | input | CW | Visible width in pixels, minus one |
| h_front_len | input | CW | Horizontal front porch in pixels, minus one |
| v_sync_len | input | CW | vsync width in lines, minus one |
| v_back_len | input | CW | Vertical back porch in lines, minus one |
| v_act_len | input | CW | Visible height in lines, minus one |
| v_front_len | input | CW | Vertical front porch in lines, minus one |
| line_thr | input | CW | Visible line index that triggers line_hit |
| irq_master_en | input | 1 | Global interrupt enable |
| irq_frame_en | input | 1 | Frame interrupt enable |
| irq_frame_sel | input | 2 | Frame interrupt source: 0 vsync, 1 active start, 2 front porch start, 3 none |
| irq_ack | input | 1 | Clears frame_irq (write-one-to-clear pulse) |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| pos_x | output | CW | Visible pixel index |
| pos_y | output | CW | Visible line index |
| frame_irq | output | 1 | Sticky frame interrupt pending flag |
| line_hit | output | 1 | Line-threshold pulse |

## Verification
The hardest situation to create from the ports is a timing rewrite in the middle of a frame. The stimulus starts one timing set and, partway through its first frame, drives a second set whose every phase length differs. A per-cycle model keeps the old geometry until its own frame wraps and only then adopts the new one, so any early adoption shows up as a mismatch in sync, enable or position. A second hard case is an acknowledge that reaches the same edge as a new vsync event. The bench places the acknowledge exactly one cycle before the predicted frame wrap to exercise it.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BACK  = 2'd1,
        PH_ACT   = 2'd2,
        PH_FRONT = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        SEL_VSYNC  = 2'd0,
        SEL_ACTIVE = 2'd1,
        SEL_FRONT  = 2'd2,
        SEL_NONE   = 2'd3
    } irq_sel_e;

    function automatic phase_e next_phase(input phase_e ph);
        phase_e r;
        unique case (ph)
            PH_SYNC:  r = PH_BACK;
            PH_BACK:  r = PH_ACT;
            PH_ACT:   r = PH_FRONT;
            default:  r = PH_SYNC;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtg_axis_seq.sv
module rtg_axis_seq
    import rtg_pkg::*;
#(
    parameter int unsigned CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          step,
    input  logic [CW-1:0] len_sync,
    input  logic [CW-1:0] len_back,
    input  logic [CW-1:0] len_act,
    input  logic [CW-1:0] len_front,
    output phase_e        phase,
    output logic [CW-1:0] cnt,
    output logic          adv
);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
    } ax_st_t;

    ax_st_t        st_d, st_q;
    logic [CW-1:0] cur_len;
    logic          at_end;

    always_comb begin
        unique case (st_q.ph)
            PH_SYNC:  cur_len = len_sync;
            PH_BACK:  cur_len = len_back;
            PH_ACT:   cur_len = len_act;
            default:  cur_len = len_front;
        endcase
        at_end = (st_q.cnt == cur_len);
        adv    = run && step && at_end;
        st_d   = st_q;
        if (!run) begin
            st_d.ph  = PH_SYNC;
            st_d.cnt = '0;
        end else if (step) begin
            if (at_end) begin
                st_d.ph  = next_phase(st_q.ph);
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph  <= PH_SYNC;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.ph;
    assign cnt   = st_q.cnt;

    // phases advance strictly in the order sync, back, active, front (R2, R3)
    assert_phase_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && (st_q.ph != $past(st_q.ph))) |-> (st_q.ph == next_phase($past(st_q.ph))));

    // the in-phase counter never passes the programmed length (R2)
    assert_cnt_in_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (st_q.cnt <= cur_len));

endmodule

// File: rtl/rtg_cfg_shadow.sv
module rtg_cfg_shadow #(
    parameter int unsigned W = 108
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] val;
    } sh_st_t;

    sh_st_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.val = d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q.val <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign q = sh_q.val;

    // working configuration only moves at a load point (R6)
    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> $stable(sh_q.val));

endmodule

// File: rtl/rtg_event_irq.sv
module rtg_event_irq
    import rtg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_vsync,
    input  logic       ev_active,
    input  logic       ev_front,
    input  logic       master_en,
    input  logic       frame_en,
    input  logic [1:0] sel,
    input  logic       ack,
    output logic       pend
);

    typedef struct packed {
        logic pend;
    } irq_st_t;

    irq_st_t  irq_d, irq_q;
    irq_sel_e sel_e;
    logic     hit_src;
    logic     set_now;

    always_comb begin
        sel_e = irq_sel_e'(sel);
        unique case (sel_e)
            SEL_VSYNC:  hit_src = ev_vsync;
            SEL_ACTIVE: hit_src = ev_active;
            SEL_FRONT:  hit_src = ev_front;
            default:    hit_src = 1'b0;
        endcase
        set_now = master_en && frame_en && hit_src;
        irq_d   = irq_q;
        if (set_now) begin
            irq_d.pend = 1'b1;
        end else if (ack) begin
            irq_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q.pend <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign pend = irq_q.pend;

    // pending flag only drops after an acknowledge (R9)
    assert_pend_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_q.pend) && !$past(ack)) |-> irq_q.pend);

    // pending flag rises only when both enables were set (R10)
    assert_set_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q.pend) |-> $past(master_en && frame_en));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int unsigned CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [CW-1:0] h_sync_len,
    input  logic [CW-1:0] h_back_len,
    input  logic [CW-1:0] h_act_len,
    input  logic [CW-1:0] h_front_len,
    input  logic [CW-1:0] v_sync_len,
    input  logic [CW-1:0] v_back_len,
    input  logic [CW-1:0] v_act_len,
    input  logic [CW-1:0] v_front_len,
    input  logic [CW-1:0] line_thr,
    input  logic          irq_master_en,
    input  logic          irq_frame_en,
    input  logic [1:0]    irq_frame_sel,
    input  logic          irq_ack,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [CW-1:0] pos_x,
    output logic [CW-1:0] pos_y,
    output logic          frame_irq,
    output logic          line_hit
);

    localparam int unsigned N_FIELDS = 9;
    localparam int unsigned CFG_W    = N_FIELDS * CW;

    typedef struct packed {
        logic [CW-1:0] hs;
        logic [CW-1:0] hb;
        logic [CW-1:0] ha;
        logic [CW-1:0] hf;
        logic [CW-1:0] vs;
        logic [CW-1:0] vb;
        logic [CW-1:0] va;
        logic [CW-1:0] vf;
        logic [CW-1:0] thr;
    } tcfg_t;

    typedef struct packed {
        logic run;
    } top_st_t;

    top_st_t       top_d, top_q;
    tcfg_t         cfg_live, cfg_act;
    logic [CFG_W-1:0] cfg_act_vec;
    logic          shadow_load;

    phase_e        h_ph, v_ph;
    logic [CW-1:0] h_cnt, v_cnt;
    logic          h_adv, v_adv;
    logic          h_wrap, frame_end;
    logic          ev_active, ev_front;

    always_comb begin
        top_d     = top_q;
        top_d.run = enable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q.run <= 1'b0;
        end else begin
            top_q <= top_d;
        end
    end

    always_comb begin
        cfg_live.hs  = h_sync_len;
        cfg_live.hb  = h_back_len;
        cfg_live.ha  = h_act_len;
        cfg_live.hf  = h_front_len;
        cfg_live.vs  = v_sync_len;
        cfg_live.vb  = v_back_len;
        cfg_live.va  = v_act_len;
        cfg_live.vf  = v_front_len;
        cfg_live.thr = line_thr;
    end

    assign shadow_load = !top_q.run || frame_end;
    assign cfg_act     = tcfg_t'(cfg_act_vec);

    rtg_cfg_shadow #(
        .W (CFG_W)
    ) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (shadow_load),
        .d     (cfg_live),
        .q     (cfg_act_vec)
    );

    rtg_axis_seq #(
        .CW (CW)
    ) u_h_axis (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (top_q.run),
        .step      (1'b1),
        .len_sync  (cfg_act.hs),
        .len_back  (cfg_act.hb),
        .len_act   (cfg_act.ha),
        .len_front (cfg_act.hf),
        .phase     (h_ph),
        .cnt       (h_cnt),
        .adv       (h_adv)
    );

    assign h_wrap = h_adv && (h_ph == PH_FRONT);

    rtg_axis_seq #(
        .CW (CW)
    ) u_v_axis (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (top_q.run),
        .step      (h_wrap),
        .len_sync  (cfg_act.vs),
        .len_back  (cfg_act.vb),
        .len_act   (cfg_act.va),
        .len_front (cfg_act.vf),
        .phase     (v_ph),
        .cnt       (v_cnt),
        .adv       (v_adv)
    );

    assign frame_end = v_adv && (v_ph == PH_FRONT);
    assign ev_active = v_adv && (v_ph == PH_BACK);
    assign ev_front  = v_adv && (v_ph == PH_ACT);

    rtg_event_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_vsync  (frame_end),
        .ev_active (ev_active),
        .ev_front  (ev_front),
        .master_en (irq_master_en),
        .frame_en  (irq_frame_en),
        .sel       (irq_frame_sel),
        .ack       (irq_ack),
        .pend      (frame_irq)
    );

    always_comb begin
        hsync    = top_q.run && (h_ph == PH_SYNC);
        vsync    = top_q.run && (v_ph == PH_SYNC);
        de       = top_q.run && (h_ph == PH_ACT) && (v_ph == PH_ACT);
        pos_x    = (top_q.run && (h_ph == PH_ACT)) ? h_cnt : '0;
        pos_y    = (top_q.run && (v_ph == PH_ACT)) ? v_cnt : '0;
        line_hit = top_q.run && (v_ph == PH_ACT) && (v_cnt == cfg_act.thr)
                   && (h_ph == PH_SYNC) && (h_cnt == '0);
    end

    // visible data never overlaps a sync pulse (R4)
    assert_de_no_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (!hsync && !vsync));

    // threshold indication lasts exactly one clock (R8)
    assert_hit_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        line_hit |=> !line_hit);

endmodule

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;

    localparam int unsigned CW = 12;

    typedef struct packed {
        logic [7:0] hs;
        logic [7:0] hb;
        logic [7:0] ha;
        logic [7:0] hf;
        logic [7:0] vs;
        logic [7:0] vb;
        logic [7:0] va;
        logic [7:0] vf;
        logic [7:0] thr;
        logic [1:0] sel;
        logic       men;
        logic       fen;
    } vec_t;

    localparam int N_VEC = 6;
    localparam vec_t VECS [N_VEC] = '{
        '{8'd1, 8'd1, 8'd3, 8'd0, 8'd0, 8'd1, 8'd2, 8'd1, 8'd1, 2'd0, 1'b1, 1'b1},
        '{8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 2'd1, 1'b1, 1'b1},
        '{8'd2, 8'd3, 8'd7, 8'd2, 8'd1, 8'd2, 8'd4, 8'd0, 8'd4, 2'd2, 1'b1, 1'b1},
        '{8'd1, 8'd0, 8'd2, 8'd1, 8'd0, 8'd0, 8'd1, 8'd0, 8'd9, 2'd3, 1'b1, 1'b1},
        '{8'd0, 8'd1, 8'd1, 8'd0, 8'd1, 8'd0, 8'd2, 8'd1, 8'd0, 2'd0, 1'b1, 1'b0},
        '{8'd0, 8'd1, 8'd1, 8'd0, 8'd1, 8'd0, 8'd2, 8'd1, 8'd0, 2'd1, 1'b0, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          enable;
    logic [CW-1:0] h_sync_len, h_back_len, h_act_len, h_front_len;
    logic [CW-1:0] v_sync_len, v_back_len, v_act_len, v_front_len;
    logic [CW-1:0] line_thr;
    logic          irq_master_en, irq_frame_en;
    logic [1:0]    irq_frame_sel;
    logic          irq_ack;
    logic          hsync, vsync, de, frame_irq, line_hit;
    logic [CW-1:0] pos_x, pos_y;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int mHS, mHB, mHA, mHF, mVS, mVB, mVA, mVF, mThr, mHT, mVT;
    int t, l, n;
    bit exp_pend;
    vec_t alt_vec;

    always #2 clk = ~clk;

    raster_timing_gen #(.CW(CW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .h_sync_len    (h_sync_len),
        .h_back_len    (h_back_len),
        .h_act_len     (h_act_len),
        .h_front_len   (h_front_len),
        .v_sync_len    (v_sync_len),
        .v_back_len    (v_back_len),
        .v_act_len     (v_act_len),
        .v_front_len   (v_front_len),
        .line_thr      (line_thr),
        .irq_master_en (irq_master_en),
        .irq_frame_en  (irq_frame_en),
        .irq_frame_sel (irq_frame_sel),
        .irq_ack       (irq_ack),
        .hsync         (hsync),
        .vsync         (vsync),
        .de            (de),
        .pos_x         (pos_x),
        .pos_y         (pos_y),
        .frame_irq     (frame_irq),
        .line_hit      (line_hit)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d (n=%0d)", req, what, act, exp, n);
        end
    endtask

    task automatic apply_cfg(input vec_t v);
        h_sync_len    = CW'(v.hs);
        h_back_len    = CW'(v.hb);
        h_act_len     = CW'(v.ha);
        h_front_len   = CW'(v.hf);
        v_sync_len    = CW'(v.vs);
        v_back_len    = CW'(v.vb);
        v_act_len     = CW'(v.va);
        v_front_len   = CW'(v.vf);
        line_thr      = CW'(v.thr);
        irq_frame_sel = v.sel;
        irq_master_en = v.men;
        irq_frame_en  = v.fen;
    endtask

    task automatic load_model();
        mHS  = int'(h_sync_len) + 1;
        mHB  = int'(h_back_len) + 1;
        mHA  = int'(h_act_len) + 1;
        mHF  = int'(h_front_len) + 1;
        mVS  = int'(v_sync_len) + 1;
        mVB  = int'(v_back_len) + 1;
        mVA  = int'(v_act_len) + 1;
        mVF  = int'(v_front_len) + 1;
        mThr = int'(line_thr);
        mHT  = mHS + mHB + mHA + mHF;
        mVT  = mVS + mVB + mVA + mVF;
    endtask

    // disable for one cycle, clear pending, load a vector, then enable
    task automatic start(input vec_t v);
        enable  = 1'b0;
        apply_cfg(v);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk("R9", "frame_irq after ack", int'(frame_irq), 0);
        chk("R1", "hsync while disabled", int'(hsync), 0);
        chk("R1", "de while disabled", int'(de), 0);
        enable = 1'b1;
        @(negedge clk);
        t = 0; l = 0; n = 0; exp_pend = 1'b0;
        load_model();
        chk("R5", "hsync at start", int'(hsync), 1);
        chk("R5", "vsync at start", int'(vsync), 1);
    endtask

    task automatic run_cycles(input int cnt, input int ack_at, input int chg_at, input string ctx);
        for (int i = 0; i < cnt; i++) begin
            bit fire, hin, vin, ehit;
            int ex, ey;
            fire = 1'b0;
            if (irq_master_en && irq_frame_en && t == 0) begin
                case (irq_frame_sel)
                    2'd0: fire = (l == 0) && (n > 0);
                    2'd1: fire = (l == mVS + mVB);
                    2'd2: fire = (l == mVS + mVB + mVA);
                    default: fire = 1'b0;
                endcase
            end
            if (fire) exp_pend = 1'b1;
            else if (irq_ack) exp_pend = 1'b0;
            hin  = (t >= mHS + mHB) && (t < mHS + mHB + mHA);
            vin  = (l >= mVS + mVB) && (l < mVS + mVB + mVA);
            ex   = hin ? t - (mHS + mHB) : 0;
            ey   = vin ? l - (mVS + mVB) : 0;
            ehit = (t == 0) && vin && (ey == mThr);
            chk({ctx, " R2"}, "hsync", int'(hsync), int'(t < mHS));
            chk({ctx, " R3"}, "vsync", int'(vsync), int'(l < mVS));
            chk({ctx, " R4"}, "de", int'(de), int'(hin && vin));
            chk({ctx, " R4"}, "pos_x", int'(pos_x), ex);
            chk({ctx, " R4"}, "pos_y", int'(pos_y), ey);
            chk({ctx, " R8"}, "line_hit", int'(line_hit), int'(ehit));
            chk({ctx, " R7"}, "frame_irq", int'(frame_irq), int'(exp_pend));
            irq_ack = (i == ack_at);
            if (i == chg_at) apply_cfg(alt_vec);
            t++;
            if (t == mHT) begin
                t = 0;
                l++;
                if (l == mVT) begin
                    l = 0;
                    load_model();
                end
            end
            n++;
            @(negedge clk);
        end
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n   = 1'b0;
        enable  = 1'b0;
        irq_ack = 1'b0;
        apply_cfg(VECS[0]);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "hsync in reset", int'(hsync), 0);
        chk("R1", "vsync in reset", int'(vsync), 0);
        chk("R1", "de in reset", int'(de), 0);
        chk("R1", "frame_irq in reset", int'(frame_irq), 0);
        chk("R1", "line_hit in reset", int'(line_hit), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector walk: each timing set for two frames
        for (int k = 0; k < N_VEC; k++) begin
            start(VECS[k]);
            run_cycles(2 * mHT * mVT + 5, -1, -1, (k >= 4) ? "R10" : "walk");
        end

        // R9: acknowledge on the same edge as a vsync event, then a plain clear
        start(VECS[0]);
        run_cycles(mHT * mVT, mHT * mVT - 1, -1, "R9");
        chk("R9", "set wins over ack", int'(frame_irq), 1);
        run_cycles(30, 10, -1, "R9");

        // R6: rewrite all timing mid-frame; old frame must finish unchanged
        alt_vec = VECS[2];
        start(VECS[0]);
        run_cycles(72 + 198 + 10, -1, 20, "R6");

        // R1: disabling mid-frame silences the outputs at once
        enable = 1'b0;
        @(negedge clk);
        chk("R1", "hsync after disable", int'(hsync), 0);
        chk("R1", "vsync after disable", int'(vsync), 0);
        chk("R1", "de after disable", int'(de), 0);
        chk("R1", "pos_x after disable", int'(pos_x), 0);
        chk("R1", "pos_y after disable", int'(pos_y), 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule